// File: doc/BRIEF.md
# Dynamic Fixed-Point Scaling Unit

This block scales a stream of signed fixed-point samples by a power of two that can change from one sample to the next. Each incoming sample carries a valid strobe, a channel tag and a gain selector. The selector indexes a small parameter table of signed shift amounts. A positive amount multiplies the sample by two to that power. A negative amount divides it, filling the vacated upper bits with copies of the sign bit. When a time-multiplexed stream shares the unit, each channel can therefore receive its own gain.

When bits below the output LSB are dropped, they are rounded by one of three build-time modes. The result is then fitted into a narrower signed output word by one of three build-time overflow policies. The output sample appears two clock cycles after the input, together with its delayed valid and channel tag. An overflow flag reports samples that did not fit.

The output LSB has the same weight as the input LSB. The selected table entry is the only thing that moves the binary point.

Top module: `dyn_scale`

## Requirements
- R1: A table entry s >= 0 yields x * 2^s when that value fits in the signed output word.
- R2: A table entry s < 0 shifts right by -s with sign extension. Truncation mode (RND_TRUNC) gives floor(x / 2^-s), and a non-negative input never yields a negative result.
- R3: The gain selector picks table entry number sel (zero-based) independently on every valid cycle. Back-to-back samples may use different entries.
- R4: Round-half-up mode (RND_HALF_UP) adds one to the floor whenever the discarded fraction is at least one half. This rounds exact ties toward plus infinity.
- R5: Convergent mode (RND_CONV) adds one when the discarded fraction is above one half, or when it is exactly one half and the floor is odd.
- R6: Wrap mode (SAT_WRAP) keeps the low OUT_W bits of the rounded value.
- R7: Symmetric mode (SAT_SYM) clamps to the range [-(2^(OUT_W-1)-1), 2^(OUT_W-1)-1]. It never outputs the most negative code.
- R8: Asymmetric mode (SAT_ASYM) clamps to the full two's-complement range [-2^(OUT_W-1), 2^(OUT_W-1)-1].
- R9: The overflow flag is 1 exactly when the output is valid and the rounded value lies outside the range of the active mode. The wrap and asymmetric modes use the full range. The flag is 0 whenever the output valid is 0.
- R10: The output data, valid and channel tag appear exactly 2 clock cycles after the input sample.
- R11: While reset is high, the output valid and the overflow flag are 0, even if the input valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | IN_W | Signed input sample |
| smp_in_vld | input | 1 | Input sample valid |
| smp_in_tag | input | CHAN_W | Input channel tag |
| gain_sel | input | SEL_W | Zero-based index into the shift table |
| smp_out | output | OUT_W | Scaled signed output sample |
| smp_out_vld | output | 1 | Output valid |
| smp_out_tag | output | CHAN_W | Output channel tag |
| smp_out_ovf | output | 1 | Overflow flag for the output sample |

## Verification
Three instances share one stimulus stream: truncate/wrap, half-up/symmetric and convergent/asymmetric. Every sample is therefore seen under each rounding and overflow policy at once.

Some samples land exactly on a half LSB, and some fall just below or above it, for both positive and negative inputs. These separate floor, half-up and round-to-even behaviour.

Some values land just inside, exactly on, and beyond the output range. These separate wrapping from symmetric and full-range clamping, and check the flag against each policy. A back-to-back stream changes the selector and tag on every cycle, with bubbles in between, to expose any misalignment of gain, data, tag and valid.

// File: rtl/dyn_scale_pkg.sv
package dyn_scale_pkg;
  typedef enum logic [1:0] {
    RND_TRUNC   = 2'd0,
    RND_HALF_UP = 2'd1,
    RND_CONV    = 2'd2
  } rnd_mode_e;

  typedef enum logic [1:0] {
    SAT_WRAP = 2'd0,
    SAT_SYM  = 2'd1,
    SAT_ASYM = 2'd2
  } sat_mode_e;
endpackage

// File: rtl/dyn_scale_shift_round.sv
module dyn_scale_shift_round import dyn_scale_pkg::*; #(
  parameter int        IN_W    = 16,
  parameter int        CHAN_W  = 3,
  parameter int        SEL_W   = 2,
  parameter int        N_SHIFT = 4,
  parameter int        SH_W    = 6,
  parameter int        EXT_W   = 25,
  parameter rnd_mode_e RND     = RND_TRUNC,
  parameter logic [N_SHIFT-1:0][SH_W-1:0] SHIFT_TAB = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic                    in_valid,
  input  logic [CHAN_W-1:0]       in_chan,
  input  logic [SEL_W-1:0]        in_sel,
  output logic signed [EXT_W-1:0] s1_val,
  output logic                    s1_valid,
  output logic [CHAN_W-1:0]       s1_chan
);
  localparam int TAB_FULL = 2 ** SEL_W;

  // Table padded to the full selector range; unused slots give unity gain.
  logic signed [SH_W-1:0] tab_full [TAB_FULL];
  for (genvar i = 0; i < TAB_FULL; i++) begin : g_tab
    if (i < N_SHIFT) begin : g_used
      assign tab_full[i] = SHIFT_TAB[i];
    end else begin : g_pad
      assign tab_full[i] = '0;
    end
  end

  logic signed [SH_W-1:0]  cur_shift;
  logic signed [EXT_W-1:0] cur_rounded;

  // Power-of-two gain with rounding of the discarded fraction.
  function automatic logic signed [EXT_W-1:0] shift_round(
    input logic signed [IN_W-1:0] x,
    input logic signed [SH_W-1:0] s
  );
    logic signed [EXT_W-1:0] xe;
    logic signed [EXT_W-1:0] fl;
    logic [EXT_W-1:0]        frac;
    logic [EXT_W-1:0]        half;
    logic                    bump;
    int                      k;
    xe = {{(EXT_W-IN_W){x[IN_W-1]}}, x};
    if (s >= 0) begin
      return xe <<< s;
    end
    k    = -int'(s);
    fl   = xe >>> k;
    frac = xe & ((EXT_W'(1) << k) - EXT_W'(1));
    half = EXT_W'(1) << (k - 1);
    case (RND)
      RND_HALF_UP: bump = (frac >= half);
      RND_CONV:    bump = (frac > half) || ((frac == half) && fl[0]);
      default:     bump = 1'b0;
    endcase
    return fl + $signed({{(EXT_W-1){1'b0}}, bump});
  endfunction

  assign cur_shift   = tab_full[in_sel];
  assign cur_rounded = shift_round(in_data, cur_shift);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_val   <= '0;
      s1_chan  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_val   <= cur_rounded;
      s1_chan  <= in_chan;
    end
  end

  AST_S1_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid); // R10

  AST_ATTEN_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cur_shift < 0 && !in_data[IN_W-1]) |=> !s1_val[EXT_W-1]); // R2
endmodule

// File: rtl/dyn_scale_saturate.sv
module dyn_scale_saturate import dyn_scale_pkg::*; #(
  parameter int        OUT_W  = 12,
  parameter int        CHAN_W = 3,
  parameter int        EXT_W  = 25,
  parameter sat_mode_e SAT    = SAT_WRAP
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [EXT_W-1:0] in_val,
  input  logic                    in_valid,
  input  logic [CHAN_W-1:0]       in_chan,
  output logic [OUT_W-1:0]        out_data,
  output logic                    out_valid,
  output logic [CHAN_W-1:0]       out_chan,
  output logic                    out_ovf
);
  localparam logic signed [EXT_W-1:0] HI      = (EXT_W'(1) <<< (OUT_W - 1)) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] LO_FULL = -HI - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] LO      = (SAT == SAT_SYM) ? -HI : LO_FULL;

  logic             range_miss;
  logic [OUT_W-1:0] fitted;

  // Returns {overflow, fitted word}.
  function automatic logic [OUT_W:0] fit_word(input logic signed [EXT_W-1:0] r);
    logic signed [EXT_W-1:0] c;
    logic                    miss;
    miss = (r > HI) || (r < LO);
    if (SAT == SAT_WRAP) begin
      c = r;
    end else if (r > HI) begin
      c = HI;
    end else if (r < LO) begin
      c = LO;
    end else begin
      c = r;
    end
    return {miss, c[OUT_W-1:0]};
  endfunction

  assign {range_miss, fitted} = fit_word(in_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ovf   <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= in_valid;
      out_ovf   <= in_valid & range_miss;
      out_data  <= fitted;
      out_chan  <= in_chan;
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R10

  AST_CHAN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && out_chan == $past(in_chan))); // R10

  AST_OVF_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> out_valid); // R9

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_val <= HI && in_val >= LO) |=>
      (!out_ovf && out_data == $past(in_val[OUT_W-1:0]))); // R9

  if (SAT == SAT_SYM) begin : g_sym_chk
    AST_SYM_FLOOR: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_data != {1'b1, {(OUT_W-1){1'b0}}})); // R7
  end
endmodule

// File: rtl/dyn_scale.sv
module dyn_scale import dyn_scale_pkg::*; #(
  parameter int        IN_W    = 16,
  parameter int        OUT_W   = 12,
  parameter int        CHAN_W  = 3,
  parameter int        SEL_W   = 2,
  parameter int        N_SHIFT = 4,
  parameter int        SH_W    = 6,
  parameter int        SHMAX   = 8,
  parameter rnd_mode_e RND     = RND_TRUNC,
  parameter sat_mode_e SAT     = SAT_WRAP,
  parameter logic [N_SHIFT-1:0][SH_W-1:0] SHIFT_TAB = {6'h3C, 6'h3F, 6'h02, 6'h00}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   smp_in,
  input  logic              smp_in_vld,
  input  logic [CHAN_W-1:0] smp_in_tag,
  input  logic [SEL_W-1:0]  gain_sel,
  output logic [OUT_W-1:0]  smp_out,
  output logic              smp_out_vld,
  output logic [CHAN_W-1:0] smp_out_tag,
  output logic              smp_out_ovf
);
  localparam int EXT_W = IN_W + SHMAX + 1;

  logic signed [EXT_W-1:0] s1_val;
  logic                    s1_valid;
  logic [CHAN_W-1:0]       s1_chan;

  dyn_scale_shift_round #(
    .IN_W(IN_W), .CHAN_W(CHAN_W), .SEL_W(SEL_W), .N_SHIFT(N_SHIFT),
    .SH_W(SH_W), .EXT_W(EXT_W), .RND(RND), .SHIFT_TAB(SHIFT_TAB)
  ) u_shift_round (
    .clk(clk), .rst(rst),
    .in_data($signed(smp_in)), .in_valid(smp_in_vld),
    .in_chan(smp_in_tag), .in_sel(gain_sel),
    .s1_val(s1_val), .s1_valid(s1_valid), .s1_chan(s1_chan)
  );

  dyn_scale_saturate #(
    .OUT_W(OUT_W), .CHAN_W(CHAN_W), .EXT_W(EXT_W), .SAT(SAT)
  ) u_saturate (
    .clk(clk), .rst(rst),
    .in_val(s1_val), .in_valid(s1_valid), .in_chan(s1_chan),
    .out_data(smp_out), .out_valid(smp_out_vld),
    .out_chan(smp_out_tag), .out_ovf(smp_out_ovf)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!smp_out_vld && !smp_out_ovf)); // R11
endmodule

// File: tb/dyn_scale_tb_top.sv
module dyn_scale_tb_top;
  import dyn_scale_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W   = 16;
  localparam int OUT_W  = 12;
  localparam int CHAN_W = 3;
  localparam int SEL_W  = 2;
  localparam int N_DUT  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0]   smp_in = '0;
  logic              smp_in_vld = 1'b0;
  logic [CHAN_W-1:0] smp_in_tag = '0;
  logic [SEL_W-1:0]  gain_sel = '0;

  logic [OUT_W-1:0]  q_d   [N_DUT];
  logic              q_v   [N_DUT];
  logic [CHAN_W-1:0] q_c   [N_DUT];
  logic              q_o   [N_DUT];

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dyn_scale #(.RND(RND_TRUNC), .SAT(SAT_WRAP)) dut_i (
    .clk(clk), .rst(rst), .smp_in(smp_in), .smp_in_vld(smp_in_vld),
    .smp_in_tag(smp_in_tag), .gain_sel(gain_sel),
    .smp_out(q_d[0]), .smp_out_vld(q_v[0]), .smp_out_tag(q_c[0]), .smp_out_ovf(q_o[0]));

  dyn_scale #(.RND(RND_HALF_UP), .SAT(SAT_SYM)) dut_hs_i (
    .clk(clk), .rst(rst), .smp_in(smp_in), .smp_in_vld(smp_in_vld),
    .smp_in_tag(smp_in_tag), .gain_sel(gain_sel),
    .smp_out(q_d[1]), .smp_out_vld(q_v[1]), .smp_out_tag(q_c[1]), .smp_out_ovf(q_o[1]));

  dyn_scale #(.RND(RND_CONV), .SAT(SAT_ASYM)) dut_cv_i (
    .clk(clk), .rst(rst), .smp_in(smp_in), .smp_in_vld(smp_in_vld),
    .smp_in_tag(smp_in_tag), .gain_sel(gain_sel),
    .smp_out(q_d[2]), .smp_out_vld(q_v[2]), .smp_out_tag(q_c[2]), .smp_out_ovf(q_o[2]));

  typedef struct {
    bit    v;
    int    x;
    int    sel;
    int    ch;
    string tag;
  } smp_t;

  smp_t hist0 = '{0, 0, 0, 0, ""};
  smp_t hist1 = '{0, 0, 0, 0, ""};

  // Default table: entry 0 -> 0, 1 -> +2, 2 -> -1, 3 -> -4
  function automatic int gain_of(int sel);
    case (sel)
      0: return 0;
      1: return 2;
      2: return -1;
      default: return -4;
    endcase
  endfunction

  // Rounding mode per instance: 0 trunc, 1 half-up, 2 convergent
  function automatic longint model_round(longint x, int s, int mode);
    longint d, q, rem;
    if (s >= 0) return x * (longint'(1) << s);
    d = longint'(1) << (-s);
    q = x / d;
    if ((x % d) != 0 && x < 0) q = q - 1;
    rem = x - q * d;
    if (mode == 1 && 2 * rem >= d) q = q + 1;
    if (mode == 2 && (2 * rem > d || (2 * rem == d && (q % 2) != 0))) q = q + 1;
    return q;
  endfunction

  // Overflow policy per instance: 0 wrap, 1 symmetric, 2 full range
  task automatic model_fit(input longint r, input int mode, output longint q, output bit ovf);
    longint hi, lo, m;
    hi  = (longint'(1) << (OUT_W - 1)) - 1;
    lo  = (mode == 1) ? -hi : -hi - 1;
    ovf = (r > hi) || (r < lo);
    if (mode == 0) begin
      m = r & ((longint'(1) << OUT_W) - 1);
      if (m > hi) m = m - (longint'(1) << OUT_W);
      q = m;
    end else begin
      q = (r > hi) ? hi : ((r < lo) ? lo : r);
    end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    for (int d = 0; d < N_DUT; d++) begin
      longint r, eq, aq;
      bit eo;
      check(q_v[d] == hist1.v, "R10", $sformatf("valid dut%0d", d), q_v[d], hist1.v);
      if (hist1.v) begin
        r  = model_round(hist1.x, gain_of(hist1.sel), d);
        model_fit(r, d, eq, eo);
        aq = longint'($signed(q_d[d]));
        check(aq == eq, hist1.tag, $sformatf("data dut%0d x=%0d sel=%0d", d, hist1.x, hist1.sel), aq, eq);
        check(q_o[d] == eo, "R9", $sformatf("ovf dut%0d x=%0d", d, hist1.x), q_o[d], eo);
        check(q_c[d] == CHAN_W'(hist1.ch), "R10", $sformatf("tag dut%0d", d), q_c[d], hist1.ch);
      end else begin
        check(q_o[d] == 1'b0, "R9", $sformatf("ovf idle dut%0d", d), q_o[d], 0);
      end
    end
  endtask

  task automatic step(bit v, int x, int sel, int ch, string tag);
    @(negedge clk);
    check_outputs();
    hist1 = hist0;
    hist0 = '{v, x, sel, ch, tag};
    smp_in_vld = v;
    smp_in     = IN_W'(x);
    gain_sel   = SEL_W'(sel);
    smp_in_tag = CHAN_W'(ch);
  endtask

  task automatic flush();
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
  endtask

  task automatic test_reset();
    smp_in_vld = 1'b1;
    smp_in = IN_W'(5000);
    gain_sel = 2'd1;
    repeat (3) begin
      @(negedge clk);
      for (int d = 0; d < N_DUT; d++) begin
        check(q_v[d] == 1'b0, "R11", "valid in reset", q_v[d], 0);
        check(q_o[d] == 1'b0, "R11", "ovf in reset", q_o[d], 0);
      end
    end
    smp_in_vld = 1'b0;
    rst = 1'b0;
    flush();
  endtask

  task automatic test_gain();
    step(1, 100, 1, 1, "R1");
    step(1, -300, 1, 2, "R1");
    step(1, 511, 1, 3, "R1");
    step(1, 1234, 0, 4, "R1");
    flush();
  endtask

  task automatic test_atten();
    step(1, -37, 3, 0, "R2");
    step(1, 37, 3, 1, "R2");
    step(1, -1, 3, 2, "R2");
    step(1, 32767, 3, 3, "R2");
    flush();
  endtask

  task automatic test_rounding();
    step(1, 5, 2, 0, "R4 R5");
    step(1, 7, 2, 1, "R4 R5");
    step(1, -5, 2, 2, "R4 R5");
    step(1, -7, 2, 3, "R4 R5");
    step(1, 24, 3, 4, "R4 R5");
    step(1, 40, 3, 5, "R4 R5");
    step(1, -24, 3, 6, "R4 R5");
    step(1, 23, 3, 7, "R4 R5");
    step(1, 25, 3, 0, "R4 R5");
    flush();
  endtask

  task automatic test_select_stream();
    for (int i = 0; i < 16; i++) begin
      step(1, (i * 37) - 250, i % 4, i % 8, "R3");
      if (i % 5 == 4) step(0, 0, 0, 0, "");
    end
    flush();
  endtask

  task automatic test_overflow();
    step(1, 1000, 1, 1, "R6 R7 R8");
    step(1, -2048, 0, 2, "R6 R7 R8");
    step(1, -600, 1, 3, "R6 R7 R8");
    step(1, 2047, 0, 4, "R6 R7 R8");
    step(1, 2048, 0, 5, "R6 R7 R8");
    step(1, -2049, 0, 6, "R6 R7 R8");
    step(1, 32767, 1, 7, "R6 R7 R8");
    step(1, -32768, 1, 0, "R6 R7 R8");
    flush();
    step(0, 0, 0, 0, "");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_gain();
    test_atten();
    test_rounding();
    test_select_stream();
    test_overflow();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule